// File: doc/BRIEF.md
# Cyclic Waveform Table Player

This block plays a stored waveform table out to a parallel DAC, such as a resistor ladder, at a fixed rate of one sample slot every four system clocks. The table sits in an on-block synchronous RAM of 512 words of 12 bits. A simple write port fills the RAM while playback is stopped. Computing the waveform values and filtering the analog output are left to the system around the block.

The played loop covers entries 0 to N-1. N is programmable, so one pass through the loop can hold one waveform period or several. Each entry can be held for a programmable number of extra slots. Together, the loop length and the hold count set the output frequency in fine steps. After the last entry the index returns to entry 0 in the very next slot, with no idle slot and no repeated slot.

New loop-length and hold settings go into a shadow register first. While the block is stopped, the shadow copies straight into the live settings. While the block is playing, the copy waits until the index steps onto a chosen marker index, which is normally placed where the waveform is flat. A one-clock pulse marks each return of the index to entry 0.

Top module: `wave_table_player`

## Requirements
- R1: While `enable` is high, `dacOut` changes only at slot boundaries, which are 4 clocks apart. The first slot's value appears after the second rising edge that sees `enable` high.
- R2: The slot after the one that shows entry N-1 shows entry 0, with no idle or duplicated slot in between.
- R3: With loop length N (`cfgLen`, legal range 3 to 511), the index steps through entries 0 to N-1 in ascending order.
- R4: With hold count R (`cfgRep`), every entry is shown for R+1 consecutive slots. R = 0 gives one slot per entry.
- R5: A clock with `cfgWe` high captures `cfgLen` and `cfgRep` into the shadow register. While `enable` is low, the shadow is copied into the live settings on the following clock.
- R6: While `enable` is low, the index is held at 0 and `dacOut` reads the mid-scale code 0x800 one clock later. The next start plays from entry 0.
- R7: `wrapPulse` is high for exactly one clock, at the edge where the index moves from N-1 to 0. That is two clocks before entry 0 reaches `dacOut`. It does not pulse when playback starts.
- R8: While playing, a shadow value written earlier takes effect at the slot boundary where the index steps onto `flatIdx`. That marker entry and everything after it use the new length and hold count, and all earlier slots use the old ones.
- R9: A clock with `wrEn` high writes `wrData` into table entry `wrAddr`. Later playback outputs the written value at that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Playback run control |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 9 | Table write address |
| wrData | input | 12 | Table write data |
| cfgWe | input | 1 | Shadow settings write strobe |
| cfgLen | input | 9 | Loop length N for the shadow register |
| cfgRep | input | 8 | Extra hold slots per entry for the shadow register |
| flatIdx | input | 9 | Marker index at which pending settings apply |
| dacOut | output | 12 | Sample to the DAC |
| wrapPulse | output | 1 | One-clock pulse when the index returns to 0 |

## Verification
The assertions rely on three conditions about the inputs:
- `cfgLen` is at least 3.
- `flatIdx` lies below both the current and the pending loop length, so the marker is always reached.
- `flatIdx` stays constant during a run.

The bench keeps to these conditions. It changes `flatIdx` and programs a starting length only while the block is stopped. Mid-run changes use lengths larger than the marker, and each is written during a slot that is not a boundary slot. The bench's reference model then knows the exact slot from which the change is pending.

// File: rtl/wavetab_pkg.sv
package wavetab_pkg;
  typedef struct packed {
    logic idle;   // playback stopped this cycle
    logic load;   // move table read data to the DAC register
    logic wrap;   // index steps from last entry to zero on this edge
  } ctrlStrb_t;
endpackage

// File: rtl/wavetab_ram.sv
module wavetab_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/wavetab_ctrl.sv
module wavetab_ctrl
  import wavetab_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int REP_W     = 8,
  parameter int SLOT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgLen,
  input  logic [REP_W-1:0]  cfgRep,
  input  logic [ADDR_W-1:0] flatIdx,
  output logic [ADDR_W-1:0] rdAddr,
  output ctrlStrb_t         strb
);
  localparam int PH_W = $clog2(SLOT_CLKS);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_CLKS - 1);
  localparam logic [PH_W-1:0] LOAD_PH = PH_W'(1);

  logic [PH_W-1:0]   phase;
  logic [REP_W-1:0]  repCnt;
  logic [ADDR_W-1:0] idx, nextIdx, actLen, shLen;
  logic [REP_W-1:0]  actRep, shRep;
  logic              pending;
  logic              advance, repDone, step, applyNow;

  assign advance  = enable && (phase == LAST_PH);
  assign repDone  = (repCnt == actRep);
  assign step     = advance && repDone;
  assign nextIdx  = (idx == actLen - ADDR_W'(1)) ? '0 : idx + ADDR_W'(1);
  assign applyNow = step && pending && (nextIdx == flatIdx);

  assign rdAddr    = idx;
  assign strb.idle = !enable;
  assign strb.load = enable && (phase == LOAD_PH);
  assign strb.wrap = step && (nextIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shLen <= ADDR_W'(16);
      shRep <= '0;
    end else if (cfgWe) begin
      shLen <= cfgLen;
      shRep <= cfgRep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      repCnt  <= '0;
      idx     <= '0;
      actLen  <= ADDR_W'(16);
      actRep  <= '0;
      pending <= 1'b0;
    end else if (!enable) begin
      phase   <= '0;
      repCnt  <= '0;
      idx     <= '0;
      actLen  <= shLen;
      actRep  <= shRep;
      pending <= 1'b0;
    end else begin
      phase <= (phase == LAST_PH) ? '0 : phase + PH_W'(1);
      if (advance) repCnt <= repDone ? '0 : repCnt + REP_W'(1);
      if (step) idx <= nextIdx;
      if (applyNow) begin
        actLen <= shLen;
        actRep <= shRep;
      end
      if (cfgWe) pending <= 1'b1;
      else if (applyNow) pending <= 1'b0;
    end
  end

  AST_IDX_IN_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |-> (idx < actLen)); // R3
  AST_WRAP_LANDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (idx == '0)); // R2
  AST_HOLD_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !repDone) |=> $stable(idx)); // R4
  AST_APPLY_AT_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && (actLen != $past(actLen))) |-> (idx == flatIdx)); // R8
endmodule

// File: rtl/wavetab_dpath.sv
module wavetab_dpath
  import wavetab_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] ramQ,
  output logic [DATA_W-1:0] dacOut,
  output logic              wrapPulse
);
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacOut    <= MID_CODE;
      wrapPulse <= 1'b0;
    end else begin
      wrapPulse <= strb.wrap;
      if (strb.idle)      dacOut <= MID_CODE;
      else if (strb.load) dacOut <= ramQ;
    end
  end

  AST_IDLE_MIDSCALE: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.idle) |-> (dacOut == MID_CODE)); // R6
  AST_OUT_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.idle) && !$past(strb.load)) |-> $stable(dacOut)); // R1
  AST_WRAP_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> !wrapPulse); // R7
endmodule

// File: rtl/wave_table_player.sv
module wave_table_player
  import wavetab_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 12,
  parameter int REP_W     = 8,
  parameter int SLOT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgLen,
  input  logic [REP_W-1:0]  cfgRep,
  input  logic [ADDR_W-1:0] flatIdx,
  output logic [DATA_W-1:0] dacOut,
  output logic              wrapPulse
);
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] ramQ;

  wavetab_ctrl #(.ADDR_W(ADDR_W), .REP_W(REP_W), .SLOT_CLKS(SLOT_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe), .cfgLen(cfgLen),
    .cfgRep(cfgRep), .flatIdx(flatIdx), .rdAddr(rdAddr), .strb(strb)
  );

  wavetab_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRam (
    .clk(clk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(ramQ)
  );

  wavetab_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ramQ(ramQ),
    .dacOut(dacOut), .wrapPulse(wrapPulse)
  );
endmodule

// File: tb/tb_wave_table_player.sv
`timescale 1ns/1ps
module tb_wave_table_player;
  localparam int AW = 9;
  localparam int DW = 12;
  localparam int RW = 8;
  localparam logic [DW-1:0] MID = 12'h800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic cfgWe = 1'b0;
  logic [AW-1:0] cfgLen = AW'(16);
  logic [RW-1:0] cfgRep = '0;
  logic [AW-1:0] flatIdx = '0;
  logic [DW-1:0] dacOut;
  logic wrapPulse;

  wave_table_player dut (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cfgWe(cfgWe), .cfgLen(cfgLen), .cfgRep(cfgRep),
    .flatIdx(flatIdx), .dacOut(dacOut), .wrapPulse(wrapPulse)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [DW-1:0] val;
    bit            wrap;
  } slot_t;

  slot_t expQ[$];
  logic [DW-1:0] tbMem [512];
  int  edgeN = 0;
  int  checks = 0;
  int  fails = 0;
  bit  monOn = 1'b0;
  logic [DW-1:0] lastVal = '0;

  always @(posedge clk) edgeN <= enable ? edgeN + 1 : 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops one expected slot per boundary and compares
  always @(negedge clk) begin
    if (monOn && edgeN >= 1) begin
      int n;
      bit wExp;
      n = edgeN - 1;
      if (n >= 1 && (n % 4) == 1 && expQ.size() > 0) begin
        slot_t e;
        e = expQ.pop_front();
        check(dacOut == e.val, "R1 R2 R3 R4 R9 slot value", dacOut, e.val);
        lastVal = e.val;
      end else if (n >= 2) begin
        check(dacOut == lastVal, "R1 hold within slot", dacOut, lastVal);
      end
      wExp = ((n % 4) == 3 && expQ.size() > 0) ? expQ[0].wrap : 1'b0;
      check(wrapPulse == wExp, "R7 wrap pulse", wrapPulse, wExp);
    end
  end

  task automatic writeTable(int first, int count, int mul, int add);
    for (int a = first; a < first + count; a++) begin
      @(negedge clk);
      wrEn = 1'b1;
      wrAddr = AW'(a);
      wrData = DW'(a * mul + add);
      tbMem[a] = DW'(a * mul + add);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver: programs settings, pushes expected slots, runs playback
  task automatic runCase(int len, int rep, int flat, int slots, int chg, int nLen, int nRep);
    int idx, rc, l, r, ni;
    bit pend, w;
    @(negedge clk);
    flatIdx = AW'(flat);
    cfgLen = AW'(len);
    cfgRep = RW'(rep);
    cfgWe = 1'b1;                       // R5 shadow write while stopped
    @(negedge clk);
    cfgWe = 1'b0;
    repeat (3) @(negedge clk);
    idx = 0; rc = 0; l = len; r = rep; pend = 0; w = 0;
    for (int s = 0; s < slots; s++) begin
      expQ.push_back('{val: tbMem[idx], wrap: w});
      if (s == chg) pend = 1;
      if (rc == r) begin
        rc = 0;
        ni = (idx == l - 1) ? 0 : idx + 1;
        w = (ni == 0);
        if (pend && ni == flat) begin   // R8 deferred apply at marker
          l = nLen;
          r = nRep;
          pend = 0;
        end
        idx = ni;
      end else begin
        rc++;
        w = 0;
      end
    end
    monOn = 1'b1;
    enable = 1'b1;
    if (chg >= 0) begin
      while (edgeN != 4 * chg + 1) @(negedge clk);
      cfgLen = AW'(nLen);
      cfgRep = RW'(nRep);
      cfgWe = 1'b1;
      @(negedge clk);
      cfgWe = 1'b0;
    end
    wait (expQ.size() == 0);
    @(negedge clk);
    monOn = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    check(dacOut == MID, "R6 idle midscale", dacOut, MID);
    check(wrapPulse == 1'b0, "R7 no pulse when idle", wrapPulse, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(dacOut == MID, "R6 reset output", dacOut, MID);
    check(wrapPulse == 1'b0, "R7 reset pulse", wrapPulse, 0);
    rstN = 1'b1;
    writeTable(0, 512, 37, 5);                  // R9 table fill
    runCase(16, 0, 0, 40, -1, 0, 0);            // R1 R2 R3 default loop
    runCase(3, 2, 0, 21, -1, 0, 0);             // R3 R4 shortest loop with hold
    runCase(300, 0, 0, 310, -1, 0, 0);          // R3 long loop wrap
    runCase(16, 0, 4, 60, 5, 8, 1);             // R8 change deferred to marker
    runCase(10, 1, 2, 40, 0, 6, 0);             // R8 change in first slot
    writeTable(0, 8, 211, 77);                  // R9 rewrite while stopped
    runCase(5, 0, 0, 20, -1, 0, 0);             // R6 restart at entry 0, R9
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule